// File: doc/BRIEF.md
# Symmetric Up-Down PWM Timer

This block is a timer/counter that runs in a symmetric pulse-width mode. The count climbs from zero to a programmable ceiling, then falls back to zero, and repeats. This gives a triangle waveform, and a single output pin is toggled against it at a programmable compare threshold. The result is a centre-aligned PWM signal. The pin's polarity is chosen by a two-bit output-mode field.

Two status flags record events. The bottom flag is set when the count turns around at zero. The match flag is set when the count equals the active threshold. Each flag drives an interrupt request when both its own enable and a global enable are set.

The threshold is double-buffered: software writes a shadow copy, and the copy moves into the active register only when the count sits at the ceiling. The edge values zero and ceiling drive the pin to fixed levels. Software programs the block through a simple write port with a two-bit register select.

Top module: `pwm_updown_timer`

## Requirements
- R1: After reset the count is 0 and rising. While rising it adds 1 per cycle until it equals the ceiling, then falls by 1 per cycle until it reaches 0, then rises again (0,1,..,T,T-1,..,1,0,1,..). The ceiling T must be at least 2.
- R2: The bottom flag (`ovf_flag_o`) is set on the clock edge at which the falling count is 0, that is, where the direction reverses at zero.
- R3: The match flag (`cmp_flag_o`) is set on every clock edge at which the count equals the active threshold.
- R4: The control register (select 2) has these bits: bit0 is the bottom interrupt enable, bit1 is the match interrupt enable, bit2 is the global enable, and bits 4:3 are the output mode. Each interrupt output equals its flag AND its own enable AND the global enable.
- R5: Writing select 3 with data bit0 or bit1 set clears the bottom or match flag respectively. A pulse on `ovf_ack`/`cmp_ack` also clears that flag. A set in the same cycle takes priority over a clear.
- R6: A write to select 1 loads the shadow threshold. The active threshold takes the shadow value on each edge where the count equals the ceiling. Select 0 writes the ceiling directly.
- R7: In output mode 2'b10 with the threshold strictly between 0 and the ceiling, a match while rising drives the pin low, and a match while falling drives it high.
- R8: In mode 2'b11 under the same conditions, a match while rising drives the pin high, and a match while falling drives it low.
- R9: In mode 2'b10 an active threshold of 0 holds the pin low, and an active threshold equal to the ceiling holds it high.
- R10: In mode 2'b11 an active threshold of 0 holds the pin high, and one equal to the ceiling holds it low.
- R11: In modes 2'b00 and 2'b01 the pin keeps its last value.
- R12: Reset clears the flags, the pin, both thresholds and the control register, and sets the ceiling to the parameter `TOP_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 ceiling, 1 shadow threshold, 2 control, 3 flag clear |
| wr_data | input | WIDTH | Write data |
| ovf_ack | input | 1 | Bottom interrupt acknowledge |
| cmp_ack | input | 1 | Match interrupt acknowledge |
| count_o | output | WIDTH | Current count |
| pwm_o | output | 1 | PWM output pin |
| ovf_flag_o | output | 1 | Bottom turnaround flag |
| cmp_flag_o | output | 1 | Compare match flag |
| ovf_irq_o | output | 1 | Bottom interrupt request |
| cmp_irq_o | output | 1 | Match interrupt request |

## Verification
The bench builds the block with WIDTH 16 and TOP_RESET 255, and writes a ceiling of 10 straight after reset. A full triangle period is therefore 20 cycles, and many periods fit in a short run. That short period brings every threshold change at the ceiling, both edge-value pin levels in both polarities, the hold modes and the flag set/clear collisions into view many times over. A 16-bit width still exercises the full-width compare paths.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [1:0] {
        SEL_TOP   = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_FLAGS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       gie;
        logic       cmp_ie;
        logic       ovf_ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int NFLAG  = 2;
    localparam int F_OVF  = 0;
    localparam int F_CMP  = 1;

    // Next pin level for the output modes that drive the pin.
    function automatic logic pin_next(input logic inv, input logic is_zero,
                                      input logic is_top, input logic hit,
                                      input logic rising, input logic cur);
        logic v;
        if (is_zero)      v = 1'b0;
        else if (is_top)  v = 1'b1;
        else if (hit)     v = !rising;
        else              return cur;
        return v ^ inv;
    endfunction
endpackage

// File: rtl/updown_counter.sv
module updown_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] cnt,
    output logic             rising,
    output logic             at_top,
    output logic             bottom_turn
);
    assign at_top      = (cnt == top);
    assign bottom_turn = !rising && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (at_top) begin
                rising <= 1'b0;
                cnt    <= cnt - 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end else begin
            if (bottom_turn) begin
                rising <= 1'b1;
                cnt    <= cnt + 1'b1;
            end else begin
                cnt    <= cnt - 1'b1;
            end
        end
    end

    a_r1_turn_at_top: assert property (@(posedge clk) disable iff (rst)
        (rising && cnt == top) |=> (!rising && cnt == $past(top) - 1'b1));
    a_r1_turn_at_zero: assert property (@(posedge clk) disable iff (rst)
        (!rising && cnt == '0) |=> (rising && cnt == 1));
endmodule

// File: rtl/compare_unit.sv
module compare_unit
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shadow_we,
    input  logic [WIDTH-1:0] shadow_in,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] top,
    input  logic             at_top,
    input  logic             rising,
    input  logic [1:0]       mode,
    output logic             hit,
    output logic             pwm
);
    logic [WIDTH-1:0] shadow_q, active_q;

    assign hit = (cnt == active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            pwm      <= 1'b0;
        end else begin
            if (shadow_we) shadow_q <= shadow_in;
            if (at_top)    active_q <= shadow_q;
            if (mode[1])
                pwm <= pin_next(mode[0], active_q == '0, active_q == top,
                                hit, rising, pwm);
        end
    end

    a_r6_active_only_at_top: assert property (@(posedge clk) disable iff (rst)
        (cnt != top) |=> $stable(active_q));
    a_r9_zero_low: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && active_q == '0) |=> !pwm);
    a_r9_top_high: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && active_q == top && top != '0) |=> pwm);
    a_r10_zero_high: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && active_q == '0) |=> pwm);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!mode[1]) |=> $stable(pwm));
endmodule

// File: rtl/event_flag.sv
module event_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/pwm_updown_timer.sv
module pwm_updown_timer
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int TOP_RESET = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ovf_ack,
    input  logic             cmp_ack,
    output logic [WIDTH-1:0] count_o,
    output logic             pwm_o,
    output logic             ovf_flag_o,
    output logic             cmp_flag_o,
    output logic             ovf_irq_o,
    output logic             cmp_irq_o
);
    localparam logic [WIDTH-1:0] TOP_INIT = WIDTH'(TOP_RESET);

    logic [WIDTH-1:0] top_q;
    ctrl_t            ctrl_q;
    logic             rising, at_top, bottom_turn, hit;
    logic [NFLAG-1:0] f_set, f_clr, f_q, f_ie;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q  <= TOP_INIT;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_TOP)  top_q  <= wr_data;
            if (sel == SEL_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    updown_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst(rst), .top(top_q), .cnt(count_o),
        .rising(rising), .at_top(at_top), .bottom_turn(bottom_turn)
    );

    compare_unit #(.WIDTH(WIDTH)) u_cmp (
        .clk(clk), .rst(rst),
        .shadow_we(wr_en && sel == SEL_CMP), .shadow_in(wr_data),
        .cnt(count_o), .top(top_q), .at_top(at_top), .rising(rising),
        .mode(ctrl_q.mode), .hit(hit), .pwm(pwm_o)
    );

    assign f_set[F_OVF] = bottom_turn;
    assign f_set[F_CMP] = hit;
    assign f_clr[F_OVF] = ovf_ack || (wr_en && sel == SEL_FLAGS && wr_data[F_OVF]);
    assign f_clr[F_CMP] = cmp_ack || (wr_en && sel == SEL_FLAGS && wr_data[F_CMP]);
    assign f_ie[F_OVF]  = ctrl_q.ovf_ie;
    assign f_ie[F_CMP]  = ctrl_q.cmp_ie;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        event_flag u_flag (
            .clk(clk), .rst(rst), .set(f_set[i]), .clr(f_clr[i]), .flag(f_q[i])
        );
    end

    assign ovf_flag_o = f_q[F_OVF];
    assign cmp_flag_o = f_q[F_CMP];
    assign ovf_irq_o  = f_q[F_OVF] && f_ie[F_OVF] && ctrl_q.gie;
    assign cmp_irq_o  = f_q[F_CMP] && f_ie[F_CMP] && ctrl_q.gie;

    a_r2_bottom_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (!rising && count_o == '0) |=> ovf_flag_o);
    a_r4_irq_needs_global: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq_o || cmp_irq_o) |-> ctrl_q.gie);
endmodule

// File: tb/pwm_updown_timer_tb.sv
module pwm_updown_timer_tb;
    localparam int W = 16;
    localparam int TR = 255;

    logic clk = 0, rst = 1;
    logic wr_en = 0, ovf_ack = 0, cmp_ack = 0;
    logic [1:0] wr_sel = 0;
    logic [W-1:0] wr_data = 0;
    logic [W-1:0] count_o;
    logic pwm_o, ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o;

    always #2 clk = ~clk;

    pwm_updown_timer #(.WIDTH(W), .TOP_RESET(TR)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .count_o(count_o), .pwm_o(pwm_o),
        .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o),
        .ovf_irq_o(ovf_irq_o), .cmp_irq_o(cmp_irq_o)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic pwm, ovf, cmp, ovf_irq, cmp_irq;
        string tag;
    } item_t;

    item_t q[$];
    int n_run = 0, n_fail = 0;
    string tag = "R1";

    // Requirement-level model state
    logic [W-1:0] m_cnt, m_top, m_act, m_buf;
    logic m_up, m_pwm, m_ovf, m_cmp;
    logic [4:0] m_ctrl;

    task automatic chk(input string t, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] sel, input logic [W-1:0] d,
                        input logic oa, input logic ca);
        logic hit, v, inv, nxt_up;
        logic [W-1:0] nxt_cnt;
        item_t it;
        wr_en = we; wr_sel = sel; wr_data = d; ovf_ack = oa; cmp_ack = ca;
        hit = (m_cnt == m_act);
        // R7 R8 R9 R10 R11: pin rules
        if (m_ctrl[4]) begin
            inv = m_ctrl[3];
            if (m_act == 0)          m_pwm = inv;
            else if (m_act == m_top) m_pwm = !inv;
            else if (hit)            m_pwm = m_up ? inv : !inv;
        end
        // R2 R3 R5: flags, set wins
        if (!m_up && m_cnt == 0) m_ovf = 1;
        else if (oa || (we && sel == 3 && d[0])) m_ovf = 0;
        if (hit) m_cmp = 1;
        else if (ca || (we && sel == 3 && d[1])) m_cmp = 0;
        // R6: buffered threshold
        if (m_cnt == m_top) m_act = m_buf;
        if (we && sel == 1) m_buf = d;
        // R1: triangle count
        if (m_up) begin
            nxt_up = (m_cnt != m_top);
            nxt_cnt = (m_cnt == m_top) ? m_cnt - 1 : m_cnt + 1;
        end else begin
            nxt_up = (m_cnt == 0);
            nxt_cnt = (m_cnt == 0) ? m_cnt + 1 : m_cnt - 1;
        end
        m_up = nxt_up; m_cnt = nxt_cnt;
        if (we && sel == 0) m_top = d;
        if (we && sel == 2) m_ctrl = d[4:0];
        it.cnt = m_cnt; it.pwm = m_pwm; it.ovf = m_ovf; it.cmp = m_cmp;
        // R4: irq gating
        it.ovf_irq = m_ovf & m_ctrl[0] & m_ctrl[2];
        it.cmp_irq = m_cmp & m_ctrl[1] & m_ctrl[2];
        it.tag = tag;
        @(posedge clk); #1;
        q.push_back(it);
        @(negedge clk);
        wr_en = 0; ovf_ack = 0; cmp_ack = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            chk({e.tag, "/R1"}, "count", count_o, e.cnt);
            chk(e.tag, "pwm", W'(pwm_o), W'(e.pwm));
            chk({e.tag, "/R2"}, "ovf_flag", W'(ovf_flag_o), W'(e.ovf));
            chk({e.tag, "/R3"}, "cmp_flag", W'(cmp_flag_o), W'(e.cmp));
            chk({e.tag, "/R4"}, "ovf_irq", W'(ovf_irq_o), W'(e.ovf_irq));
            chk({e.tag, "/R4"}, "cmp_irq", W'(cmp_irq_o), W'(e.cmp_irq));
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_cnt = 0; m_up = 1; m_top = W'(TR); m_act = 0; m_buf = 0;
        m_pwm = 0; m_ovf = 0; m_cmp = 0; m_ctrl = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "count", count_o, 0);
        chk("R12", "pwm", W'(pwm_o), 0);
        chk("R12", "flags", W'({ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o}), 0);
        rst = 0;
        tag = "R1";
        step(1, 0, 10, 0, 0);            // ceiling 10
        step(1, 1, 4, 0, 0);             // shadow threshold 4 (R6)
        tag = "R7";
        step(1, 2, 5'b10111, 0, 0);      // mode 10, all enables
        idle(45);
        tag = "R5";
        step(1, 3, 3, 0, 0);             // write-one-to-clear both
        idle(3);
        step(0, 0, 0, 1, 1);             // acks
        idle(7);
        tag = "R4";
        step(1, 2, 5'b10001, 0, 0);      // global off
        idle(12);
        step(1, 2, 5'b10110, 0, 0);
        idle(12);
        tag = "R9";
        step(1, 1, 0, 0, 0);
        idle(30);
        step(1, 1, 10, 0, 0);
        idle(30);
        tag = "R8";
        step(1, 2, 5'b11111, 0, 0);
        step(1, 1, 6, 0, 0);
        idle(45);
        tag = "R10";
        step(1, 1, 0, 0, 0);
        idle(30);
        step(1, 1, 10, 0, 0);
        idle(30);
        tag = "R11";
        step(1, 1, 3, 0, 0);
        step(1, 2, 5'b00111, 0, 0);
        idle(25);
        step(1, 2, 5'b01111, 0, 0);
        idle(25);
        tag = "R6";
        step(1, 2, 5'b10111, 0, 0);
        step(1, 1, 7, 0, 0);
        idle(5);
        step(1, 1, 2, 0, 0);
        idle(40);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule